// File: doc/BRIEF.md
# Serial Decimal Character Adder

This block adds or subtracts two decimal fields of variable length held in a small on-chip character store. Each store location holds one character: a 4-bit BCD digit in bits 3:0 and a sign flag in bit 4. An operand is named by two addresses. The first address is its most significant location and sits at the lower address. The last address is its least significant location. One digit adder works through both fields from the least significant location upward, one digit pair per clock. The carry from each pair is held in a flip-flop and enters the next pair. Each result digit is written back over the second operand, so the width of a sum is bounded only by the store.

A host port loads and reads the store while the block is idle. A one-cycle `start` pulse passes in the four addresses and three controls. `sub` negates the first operand. `alg` makes the sign flags on the least significant locations count. `no_recomp` keeps a negative raw result in ten's-complement form. When the effective signs differ, the block adds the nines' complement of the first operand with an initial carry of one. If that pass ends with no carry, the raw result is the complement of the answer. A second serial pass then recomplements it unless `no_recomp` was given. A last write puts the result sign on the second operand's least significant location.

The controller has five states. IDLE waits for `start`, which moves it to ADD. ADD runs the main pass. From its last digit it goes to RECOMP when a recomplement is due, and to SIGN otherwise. RECOMP runs the recomplement pass and then goes to SIGN. SIGN writes the sign flag and goes to DONE. DONE raises `done` for one cycle and returns to IDLE.

Top module: `serial_dec_adder`

## Requirements
- R1: Digit pairs are processed from the least significant location (the last address) toward the most significant location (the first address). Each result digit replaces the second operand's digit at the same position. The first operand's locations are never modified.
- R2: A carry out of one digit pair is added into the next more significant pair. Example: 275 + 0436 gives 0711.
- R3: With `alg`=1, an operand whose least significant location has bit 4 set is negative. With `alg`=0, the bit 4 flags of both inputs have no effect and both operands count as positive.
- R4: With `sub`=1, the first operand's sign is inverted, and the result is second minus first. A difference of effective signs is computed as the second operand plus the nines' complement of the first, with an initial carry of one.
- R5: When the first operand is shorter than the second, its missing high digits count as zero. The pass length is the length of the second operand.
- R6: If the complement addition ends with no carry out, the magnitude is recomplemented in a second pass to its true value. The result sign is then the opposite of the second operand's sign.
- R7: With `no_recomp`=1, a complement addition that ends with no carry leaves the ten's complement of the magnitude in the field. The sign is still the opposite of the second operand's sign.
- R8: The result sign is written to bit 4 of the second operand's least significant location and shown on `neg`. Bit 4 of every other location in the second operand is cleared. When signs match, or the complement addition ends with a carry, the sign is the second operand's sign, and that includes a zero result.
- R9: `ovf` rises when a same-sign addition carries out of the most significant digit of the second operand. The field then keeps the low digits. `ovf` is cleared by an accepted `start`, and it and `neg` hold while idle.
- R10: `done` is high for exactly one cycle. For an L-digit second operand it appears L+2 cycles after the `start` edge, or 2L+2 with a recomplement pass. `busy` is high from the cycle after `start` until the cycle after `done`.
- R11: While `busy` is high, `start` and host writes are ignored.
- R12: After reset the block is idle, `done`, `neg` and `ovf` are low, and every store location reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| sub | input | 1 | Subtract the first operand from the second |
| alg | input | 1 | Honour the sign flags of the operands |
| no_recomp | input | 1 | Leave a negative raw result in complement form |
| op1_first | input | AW | Most significant location of operand 1 |
| op1_last | input | AW | Least significant location of operand 1 |
| op2_first | input | AW | Most significant location of operand 2 (result) |
| op2_last | input | AW | Least significant location of operand 2 (result) |
| host_we | input | 1 | Host write strobe (idle only) |
| host_waddr | input | AW | Host write address |
| host_wdata | input | 5 | Host write character {sign, BCD} |
| host_raddr | input | AW | Host read address |
| host_rdata | output | 5 | Character at host_raddr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| neg | output | 1 | Sign of the last result |
| ovf | output | 1 | Carry lost from the last same-sign addition |

## Verification
The bench goes after the carry that crosses digit boundaries, the zero padding of a short first operand, and the boundary between the complement-add cases with and without a carry. A design that lost the held carry would produce 0601 instead of 0711. A design that got the carry test backwards would recomplement a correct difference, or leave a complement as the final answer. It also tests `no_recomp`, equal magnitudes giving a positive zero, the ignored sign flags when `alg` is low, and overflow on 999+1. Each of these would show up as a wrong sign bit or a stray `ovf`. Latency is counted exactly, and the bench also tries a host write and a second `start` while busy. An off-by-one pass length or a store that accepts writes mid-operation would corrupt the result or the first operand.

// File: rtl/sda_pkg.sv
package sda_pkg;
    localparam int DIG_W  = 4;
    localparam int CHAR_W = DIG_W + 1;

    typedef struct packed {
        logic             neg;
        logic [DIG_W-1:0] dig;
    } sda_char_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADD,
        ST_RECOMP,
        ST_SIGN,
        ST_DONE
    } sda_state_e;
endpackage

// File: rtl/sda_digit_add.sv
module sda_digit_add
    import sda_pkg::*;
(
    input  logic [DIG_W-1:0] a,
    input  logic [DIG_W-1:0] b,
    input  logic             cin,
    output logic [DIG_W-1:0] s,
    output logic             cout
);
    logic [DIG_W:0] raw;

    always_comb begin
        raw  = {1'b0, a} + {1'b0, b} + {{DIG_W{1'b0}}, cin};
        cout = (raw > 5'd9);
        s    = cout ? DIG_W'(raw - 5'd10) : raw[DIG_W-1:0];
    end
endmodule

// File: rtl/sda_store.sv
module sda_store
    import sda_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  sda_char_t       wdata,
    input  logic [AW-1:0]   raddr_a,
    output sda_char_t       rdata_a,
    input  logic [AW-1:0]   raddr_b,
    output sda_char_t       rdata_b,
    input  logic [AW-1:0]   raddr_c,
    output sda_char_t       rdata_c
);
    sda_char_t cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
    assign rdata_c = cells[raddr_c];
endmodule

// File: rtl/serial_dec_adder.sv
module serial_dec_adder
    import sda_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sub,
    input  logic          alg,
    input  logic          no_recomp,
    input  logic [AW-1:0] op1_first,
    input  logic [AW-1:0] op1_last,
    input  logic [AW-1:0] op2_first,
    input  logic [AW-1:0] op2_last,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic [4:0]    host_wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [4:0]    host_rdata,
    output logic          busy,
    output logic          done,
    output logic          neg,
    output logic          ovf
);
    sda_state_e state_q, state_d;

    logic [AW-1:0] k_q, lsl1_q, lsl2_q;
    logic [LW-1:0] len1_q, len2_q;
    logic          carry_q, cmpl_q, s2_q, norc_q, neg_q, ovf_q;

    logic [AW-1:0] addr1, addr2, st_waddr;
    sda_char_t     rd1, rd2, rdh, st_wdata;
    logic          st_we;
    logic [3:0]    op1_dig, add_a, add_b, sum_dig;
    logic          add_cin, add_cout, last_dig, go;
    logic          sa_start, sb_start;

    // Operand addressing: walk downward from the least significant location
    assign addr1    = (state_q == ST_IDLE) ? op1_last : lsl1_q - k_q;
    assign addr2    = (state_q == ST_IDLE) ? op2_last : lsl2_q - k_q;
    assign last_dig = ({1'b0, k_q} == len2_q - LW'(1));
    assign go       = start && (state_q == ST_IDLE);

    // Effective signs at the moment of start
    assign sb_start = alg & rd2.neg;
    assign sa_start = (alg & rd1.neg) ^ sub;

    always_comb begin
        op1_dig = ({1'b0, k_q} < len1_q) ? rd1.dig : 4'd0;
        if (state_q == ST_RECOMP) begin
            add_a = 4'd9 - rd2.dig;
            add_b = 4'd0;
        end else begin
            add_a = cmpl_q ? 4'd9 - op1_dig : op1_dig;
            add_b = rd2.dig;
        end
        add_cin = carry_q;
    end

    sda_digit_add u_add (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_cin),
        .s    (sum_dig),
        .cout (add_cout)
    );

    // Store write port: host while idle, engine otherwise
    always_comb begin
        st_we    = 1'b0;
        st_waddr = host_waddr;
        st_wdata = sda_char_t'(host_wdata);
        unique case (state_q)
            ST_IDLE: st_we = host_we;
            ST_ADD, ST_RECOMP: begin
                st_we    = 1'b1;
                st_waddr = addr2;
                st_wdata = '{neg: 1'b0, dig: sum_dig};
            end
            ST_SIGN: begin
                st_we    = 1'b1;
                st_waddr = addr2;
                st_wdata = '{neg: neg_q, dig: rd2.dig};
            end
            ST_DONE: st_we = 1'b0;
        endcase
    end

    sda_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (st_we),
        .waddr   (st_waddr),
        .wdata   (st_wdata),
        .raddr_a (addr1),
        .rdata_a (rd1),
        .raddr_b (addr2),
        .rdata_b (rd2),
        .raddr_c (host_raddr),
        .rdata_c (rdh)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ADD;
            ST_ADD:    if (last_dig)
                           state_d = (cmpl_q && !add_cout && !norc_q) ? ST_RECOMP : ST_SIGN;
            ST_RECOMP: if (last_dig) state_d = ST_SIGN;
            ST_SIGN:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q <= '0; lsl1_q <= '0; lsl2_q <= '0;
            len1_q <= '0; len2_q <= '0;
            carry_q <= 1'b0; cmpl_q <= 1'b0; s2_q <= 1'b0;
            norc_q <= 1'b0; neg_q <= 1'b0; ovf_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go) begin
                    lsl1_q  <= op1_last;
                    lsl2_q  <= op2_last;
                    len1_q  <= {1'b0, op1_last} - {1'b0, op1_first} + LW'(1);
                    len2_q  <= {1'b0, op2_last} - {1'b0, op2_first} + LW'(1);
                    k_q     <= '0;
                    cmpl_q  <= sa_start ^ sb_start;
                    carry_q <= sa_start ^ sb_start;
                    s2_q    <= sb_start;
                    norc_q  <= no_recomp;
                    ovf_q   <= 1'b0;
                    neg_q   <= 1'b0;
                end
                ST_ADD: begin
                    carry_q <= add_cout;
                    if (last_dig) begin
                        k_q   <= '0;
                        ovf_q <= !cmpl_q && add_cout;
                        neg_q <= (cmpl_q && !add_cout) ? !s2_q : s2_q;
                        if (cmpl_q && !add_cout && !norc_q) carry_q <= 1'b1;
                    end else begin
                        k_q <= k_q + AW'(1);
                    end
                end
                ST_RECOMP: begin
                    carry_q <= add_cout;
                    k_q     <= last_dig ? '0 : k_q + AW'(1);
                end
                ST_SIGN, ST_DONE: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        neg        = neg_q;
        ovf        = ovf_q;
        host_rdata = rdh;
    end
endmodule

// File: rtl/sda_checker.sv
module sda_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic neg,
    input logic ovf
);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 !busy);

    p_start_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_ovf_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !ovf);

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(ovf) && $stable(neg)));

    p_ovf_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |=> done);
endmodule

bind serial_dec_adder sda_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .neg   (neg),
    .ovf   (ovf)
);

// File: tb/serial_dec_adder_test.sv
module serial_dec_adder_test;
    localparam int DEPTH = 32;
    localparam int AW = $clog2(DEPTH);
    localparam int OP1_AT = 0;
    localparam int OP2_AT = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, sub = 0, alg = 0, no_recomp = 0;
    logic [AW-1:0] op1_first = '0, op1_last = '0, op2_first = '0, op2_last = '0;
    logic host_we = 0;
    logic [AW-1:0] host_waddr = '0, host_raddr = '0;
    logic [4:0] host_wdata = '0, host_rdata;
    logic busy, done, neg, ovf;

    int checks = 0, failures = 0, cycles = 0;

    serial_dec_adder #(.DEPTH(DEPTH)) uut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++; checks++;
            $display("FAIL R10 watchdog actual=%0d expected<=100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint p10(int n);
        longint r = 1;
        for (int i = 0; i < n; i++) r *= 10;
        return r;
    endfunction

    task automatic host_wr(int a, logic [4:0] d);
        @(negedge clk);
        host_we = 1; host_waddr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic put_field(int msl, int len, longint mag, bit sgn);
        for (int i = 0; i < len; i++)
            host_wr(msl + len - 1 - i, {(i == 0) ? sgn : 1'b0, 4'((mag / p10(i)) % 10)});
    endtask

    task automatic get_field(int msl, int len, output longint mag, output bit sgn, output bit stray);
        mag = 0; stray = 0; sgn = 0;
        for (int i = 0; i < len; i++) begin
            host_raddr = AW'(msl + len - 1 - i);
            #1;
            mag += longint'(host_rdata[3:0]) * p10(i);
            if (i == 0) sgn = host_rdata[4];
            else if (host_rdata[4]) stray = 1;
        end
    endtask

    // Generic operation: load, run, compare with a sign-magnitude model
    task automatic run_case(string tag, longint m1, bit s1, int l1, longint m2, bit s2, int l2,
                            bit do_sub, bit do_alg, bit nr, bit meddle);
        bit e1, e2, esgn, eovf, recomp, gsgn, stray, o1s, o1stray;
        longint emag, diff, p, gmag, o1mag;
        int cyc, elat;
        put_field(OP1_AT, l1, m1, s1);
        put_field(OP2_AT, l2, m2, s2);
        e1 = (do_alg & s1) ^ do_sub;
        e2 = do_alg & s2;
        p = p10(l2);
        recomp = 0; eovf = 0;
        if (e1 == e2) begin
            emag = (m1 + m2) % p; eovf = (m1 + m2) >= p; esgn = e2;
        end else begin
            diff = m2 - m1;
            if (diff >= 0) begin emag = diff; esgn = e2; end
            else if (!nr) begin emag = -diff; esgn = !e2; recomp = 1; end
            else begin emag = p + diff; esgn = !e2; end
        end
        elat = l2 + 2 + (recomp ? l2 : 0);
        @(negedge clk);
        start = 1; sub = do_sub; alg = do_alg; no_recomp = nr;
        op1_first = AW'(OP1_AT); op1_last = AW'(OP1_AT + l1 - 1);
        op2_first = AW'(OP2_AT); op2_last = AW'(OP2_AT + l2 - 1);
        @(negedge clk);
        start = 0;
        cyc = 1;
        while (!done && cyc < 1000) begin
            if (meddle && cyc == 2) begin
                // R11: stray start and host write while busy
                start = 1; op2_last = AW'(OP2_AT); host_we = 1;
                host_waddr = AW'(OP1_AT); host_wdata = 5'h17;
            end else begin
                start = 0; host_we = 0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 0; host_we = 0;
        chk(cyc == elat, {tag, " R10 done latency"}, cyc, elat);
        chk(ovf == eovf, {tag, " R9 ovf"}, ovf, eovf);
        chk(neg == esgn, {tag, " R8 neg output"}, neg, esgn);
        @(negedge clk);
        chk(!done, {tag, " R10 done single cycle"}, done, 0);
        chk(!busy, {tag, " R10 busy drops"}, busy, 0);
        get_field(OP2_AT, l2, gmag, gsgn, stray);
        chk(gmag == emag, {tag, " R1 result digits"}, gmag, emag);
        chk(gsgn == esgn && !stray, {tag, " R8 sign flags"}, {gsgn, stray}, {esgn, 1'b0});
        get_field(OP1_AT, l1, o1mag, o1s, o1stray);
        chk(o1mag == m1 && o1s == s1, {tag, " R1 R11 op1 untouched"}, o1mag, m1);
    endtask

    task automatic t_reset;
        logic [4:0] d;
        chk(!busy && !done, "R12 idle after reset", {busy, done}, 0);
        chk(!neg && !ovf, "R12 flags clear", {neg, ovf}, 0);
        host_raddr = AW'(OP2_AT); #1; d = host_rdata;
        chk(d == 0, "R12 store cleared", d, 0);
    endtask

    task automatic t_carry;      run_case("R2 carry",      275, 0, 3, 436, 0, 4, 0, 0, 0, 0); endtask
    task automatic t_pad;        run_case("R5 pad",          7, 0, 1, 4321, 0, 4, 0, 0, 0, 0); endtask
    task automatic t_sub_pos;    run_case("R4 sub pos",    123, 0, 3, 500, 0, 3, 1, 0, 0, 0); endtask
    task automatic t_sub_neg;    run_case("R6 recomp",     500, 0, 3, 123, 0, 3, 1, 0, 0, 0); endtask
    task automatic t_norc;       run_case("R7 norecomp",   500, 0, 3, 123, 0, 3, 1, 0, 1, 0); endtask
    task automatic t_alg_mix;
        run_case("R3 alg neg1",  45, 1, 2, 100, 0, 3, 0, 1, 0, 0);
        run_case("R3 alg neg2",  45, 0, 2, 100, 1, 3, 0, 1, 0, 0);
        run_case("R6 alg recomp", 200, 1, 3, 45, 0, 3, 0, 1, 0, 0);
        run_case("R3 both neg",   12, 1, 2, 30, 1, 3, 0, 1, 0, 0);
    endtask
    task automatic t_alg_off;    run_case("R3 flags off",   45, 1, 2, 100, 1, 3, 0, 0, 0, 0); endtask
    task automatic t_overflow;
        run_case("R9 overflow",  1, 0, 1, 999, 0, 3, 0, 0, 0, 0);
        run_case("R9 ovf clear", 1, 0, 1, 998, 0, 3, 0, 0, 0, 0);
    endtask
    task automatic t_zero;       run_case("R8 zero",       250, 0, 3, 250, 0, 3, 1, 0, 0, 0); endtask
    task automatic t_busy;       run_case("R11 busy",      164, 0, 3, 325, 0, 4, 0, 0, 0, 1); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_carry();
        t_pad();
        t_sub_pos();
        t_sub_neg();
        t_norc();
        t_alg_mix();
        t_alg_off();
        t_overflow();
        t_zero();
        t_busy();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule